// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor core from normal execution into an exception handler. When the core raises `start_i`, the block takes a snapshot of the pending exception class, the program counter, the delay-slot count and the special registers. From the snapshot it works out the vector number and the return addresses. If the core was in user mode, it swaps to the kernel stack. It also rewrites the condition/status word and reads the handler address from the vector table in memory.

The vector table is read through a memory port that carries one word per request and a valid/ready request handshake. The block never has more than one request outstanding. The updated register set and the new program counter appear on the outputs all at once, in the same cycle as the one-cycle `done_o` pulse. While the fetch is in flight, the outputs keep their previous values.

The entry behaviour depends on the core version number. Versions at or above `LEGACY_VER_LIMIT` (default 32) take the full path, which includes the status-word history shift, the exception-index register and the delay-slot rewind. Older versions take a reduced path and set an interrupt-lock flag. On an older version a bus fault cannot be entered, so it is reported through `err_o`.

Top module: `exc_entry_seq`

## Requirements
- R1: The vector is chosen from `cls_i`. Code 0 (interrupt) uses `irq_vec_i`, code 1 (break) uses `trap_vec_i`, code 2 (NMI) uses vector 0 and code 3 (bus fault) uses `fault_vec_i`.
- R2: Each entry issues exactly one read request at address `ebp_i + 4*vector`, wrapping at 32 bits. The request stays valid with a stable address until it is accepted, and the response word becomes `pc_o`.
- R3: Interrupt, break and bus-fault entries write the return PC to `erp_o` and pass `nrp_i` through. An NMI writes `pc_i` to `nrp_o`, clears status bit `M_BIT` (default 9), and takes `erp_o` from `erp_i`.
- R4: On the full path, `exs_o` holds the low 8 bits of the vector in bits 15:8 and zero in every other bit. On the legacy path, `exs_o` equals `exs_i`.
- R5: On the full path, the `dslot_i` count is subtracted from the ERP value of R3 and `dslot_o` is 0. On the legacy path there is no subtraction and `dslot_o` equals `dslot_i`.
- R6: If status bit `U_BIT` (default 8) of `ccs_i` is set, `usp_o` takes `sp_i` and `sp_o` takes `ksp_i`. Otherwise `usp_o` equals `usp_i` and `sp_o` equals `sp_i`.
- R7: On the full path, the new status word keeps bits 31:30 of the status word after R3, moves its bits 19:0 into bits 29:10 and clears bits 9:0, which clears the user flag. On the legacy path, the status word is unshifted.
- R8: A legacy entry sets `locked_o` to 1. A full-path entry leaves `locked_o` unchanged.
- R9: A bus fault (code 3) started with a version below the limit pulses `err_o` for one cycle. It issues no memory request, does not assert `busy_o`, and leaves all register outputs unchanged.
- R10: `busy_o` is high from the cycle after an accepted start until the response is taken. `done_o` is a one-cycle pulse in the cycle after the response is taken. Register outputs change only in that cycle, and `start_i` has no effect while busy.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin exception entry (taken when idle) |
| cls_i | input | 2 | Exception class code |
| ver_i | input | VER_W | Core version number |
| pc_i | input | 32 | Current program counter |
| dslot_i | input | DS_W | Pending delay-slot count |
| ccs_i | input | 32 | Condition/status word |
| ebp_i | input | 32 | Vector table base |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Kernel stack pointer |
| usp_i | input | 32 | Saved user stack pointer |
| erp_i | input | 32 | Exception return register |
| nrp_i | input | 32 | NMI return register |
| exs_i | input | 32 | Exception status register |
| trap_vec_i | input | 8 | Break vector |
| fault_vec_i | input | 8 | Bus-fault vector |
| irq_vec_i | input | 8 | Interrupt controller vector |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | Entry complete, outputs updated |
| err_o | output | 1 | Illegal legacy bus fault |
| mem_req_valid_o | output | 1 | Vector read request valid |
| mem_req_ready_i | input | 1 | Vector read request accepted |
| mem_addr_o | output | 32 | Vector read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data (handler address) |
| pc_o | output | 32 | New program counter |
| erp_o | output | 32 | Updated exception return register |
| nrp_o | output | 32 | Updated NMI return register |
| ccs_o | output | 32 | Updated status word |
| exs_o | output | 32 | Updated exception status |
| sp_o | output | 32 | Updated stack pointer |
| usp_o | output | 32 | Updated user stack pointer |
| dslot_o | output | DS_W | Delay-slot state after entry |
| locked_o | output | 1 | Interrupt lock flag |

## Verification
The bench sweeps every exception class against four version numbers, two on each side of the limit. Each of these is combined with the user flag on and off and with every delay-slot count, and with fetch latencies of zero to two cycles.

The class sweep separates the four vector sources through the fetch address. The version sweep separates the full path from the legacy path through the EXS value, the status-word shift, the delay-slot rewind and the lock flag. The user-flag sweep shows whether the stack swap happened. The delay-slot sweep shows whether the return address was rewound.

Extra runs cover a table base that wraps past the top of the address space and a start pulse issued while the block is busy. Legacy bus faults are covered by the sweep itself, where they must produce an error with no fetch.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN  = 32;
    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        EXC_IRQ    = 2'd0,
        EXC_BREAK  = 2'd1,
        EXC_NMI    = 2'd2,
        EXC_BUSERR = 2'd3
    } exc_cls_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic [XLEN-1:0] erp;
        logic [XLEN-1:0] nrp;
        logic [XLEN-1:0] ccs;
        logic [XLEN-1:0] exs;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] usp;
    } ctx_t;

    // history shift of the status word: top two bits stay, low 20 move up by 10
    function automatic logic [XLEN-1:0] ccs_push(input logic [XLEN-1:0] c);
        return {c[31:30], c[19:0], 10'b0};
    endfunction

    function automatic logic [XLEN-1:0] exs_pack(input logic [VEC_W-1:0] v);
        logic [XLEN-1:0] r;
        r = '0;
        r[8 +: VEC_W] = v;
        return r;
    endfunction

    function automatic logic [XLEN-1:0] vec_addr(input logic [XLEN-1:0] base,
                                                 input logic [VEC_W-1:0] v);
        return base + {{(XLEN-VEC_W-2){1'b0}}, v, 2'b00};
    endfunction

endpackage

// File: rtl/exc_vec_select.sv
module exc_vec_select
    import exc_entry_pkg::*;
(
    input  exc_cls_e          cls,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [VEC_W-1:0]  fault_vec,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic [VEC_W-1:0]  vec,
    output logic              is_nmi
);

    always_comb begin
        is_nmi = 1'b0;
        unique case (cls)
            EXC_BREAK:  vec = trap_vec;
            EXC_NMI: begin
                vec    = '0;
                is_nmi = 1'b1;
            end
            EXC_BUSERR: vec = fault_vec;
            default:    vec = irq_vec;
        endcase
    end

endmodule

// File: rtl/exc_ctx_update.sv
module exc_ctx_update
    import exc_entry_pkg::*;
#(
    parameter int DS_W  = 2,
    parameter int U_BIT = 8,
    parameter int M_BIT = 9
) (
    input  ctx_t              cur,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   ksp,
    input  logic [DS_W-1:0]   dslot,
    input  logic              is_nmi,
    input  logic [VEC_W-1:0]  vec,
    input  logic              legacy,
    output ctx_t              nxt,
    output logic [DS_W-1:0]   dslot_nxt
);

    localparam logic [XLEN-1:0] M_MASK = XLEN'(1) << M_BIT;

    logic [XLEN-1:0] rewind;
    logic [XLEN-1:0] ccs_w;

    always_comb begin
        rewind = legacy ? '0 : XLEN'(dslot);
        ccs_w  = is_nmi ? (cur.ccs & ~M_MASK) : cur.ccs;

        nxt = cur;
        if (is_nmi) begin
            nxt.nrp = pc;
            nxt.erp = cur.erp - rewind;
        end else begin
            nxt.erp = pc - rewind;
        end

        if (cur.ccs[U_BIT]) begin
            nxt.usp = cur.sp;
            nxt.sp  = ksp;
        end

        if (legacy) begin
            nxt.ccs   = ccs_w;
            dslot_nxt = dslot;
        end else begin
            nxt.ccs   = ccs_push(ccs_w);
            nxt.exs   = exs_pack(vec);
            dslot_nxt = '0;
        end
    end

endmodule

// File: rtl/exc_fetch_fsm.sv
module exc_fetch_fsm
    import exc_entry_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic illegal,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic accept,
    output logic commit,
    output logic busy,
    output logic req_valid,
    output logic err,
    output logic done
);

    fetch_state_e state_q;
    logic         idle;

    always_comb begin
        idle      = (state_q == FS_IDLE);
        accept    = start && idle && !illegal;
        commit    = (state_q == FS_WAIT) && rsp_valid;
        busy      = !idle;
        req_valid = (state_q == FS_REQ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            err     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= commit;
            err  <= start && idle && illegal;
            unique case (state_q)
                FS_IDLE: if (accept)    state_q <= FS_REQ;
                FS_REQ:  if (req_ready) state_q <= FS_WAIT;
                FS_WAIT: if (rsp_valid) state_q <= FS_IDLE;
                default:                state_q <= FS_IDLE;
            endcase
        end
    end

    // R10: done follows a taken response by exactly one cycle
    a_r10_done_after_rsp: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_WAIT && rsp_valid) |=> done);

    // R2: an unaccepted request is still offered next cycle
    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> req_valid);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int VER_W            = 8,
    parameter int DS_W             = 2,
    parameter int LEGACY_VER_LIMIT = 32,
    parameter int U_BIT            = 8,
    parameter int M_BIT            = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        cls_i,
    input  logic [VER_W-1:0]  ver_i,
    input  logic [31:0]       pc_i,
    input  logic [DS_W-1:0]   dslot_i,
    input  logic [31:0]       ccs_i,
    input  logic [31:0]       ebp_i,
    input  logic [31:0]       sp_i,
    input  logic [31:0]       ksp_i,
    input  logic [31:0]       usp_i,
    input  logic [31:0]       erp_i,
    input  logic [31:0]       nrp_i,
    input  logic [31:0]       exs_i,
    input  logic [7:0]        trap_vec_i,
    input  logic [7:0]        fault_vec_i,
    input  logic [7:0]        irq_vec_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [31:0]       mem_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [31:0]       mem_rsp_data_i,
    output logic [31:0]       pc_o,
    output logic [31:0]       erp_o,
    output logic [31:0]       nrp_o,
    output logic [31:0]       ccs_o,
    output logic [31:0]       exs_o,
    output logic [31:0]       sp_o,
    output logic [31:0]       usp_o,
    output logic [DS_W-1:0]   dslot_o,
    output logic              locked_o
);

    localparam logic [VER_W-1:0] VER_LIM = VER_W'(LEGACY_VER_LIMIT);

    // snapshot taken at an accepted start
    exc_cls_e          cls_q;
    logic              legacy_q;
    logic [XLEN-1:0]   pc_q, ebp_q, ksp_q;
    logic [DS_W-1:0]   dslot_q;
    logic [VEC_W-1:0]  trap_q, fault_q, irq_q;
    ctx_t              ctx_q;

    // committed state
    ctx_t              ctx_o_q;

    logic              legacy_in, illegal;
    logic              accept, commit;
    logic [VEC_W-1:0]  vec;
    logic              is_nmi;
    ctx_t              ctx_nxt;
    logic [DS_W-1:0]   dslot_nxt;

    always_comb begin
        legacy_in = (ver_i < VER_LIM);
        illegal   = legacy_in && (exc_cls_e'(cls_i) == EXC_BUSERR);
    end

    exc_fetch_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .illegal   (illegal),
        .req_ready (mem_req_ready_i),
        .rsp_valid (mem_rsp_valid_i),
        .accept    (accept),
        .commit    (commit),
        .busy      (busy_o),
        .req_valid (mem_req_valid_o),
        .err       (err_o),
        .done      (done_o)
    );

    exc_vec_select u_vsel (
        .cls       (cls_q),
        .trap_vec  (trap_q),
        .fault_vec (fault_q),
        .irq_vec   (irq_q),
        .vec       (vec),
        .is_nmi    (is_nmi)
    );

    exc_ctx_update #(
        .DS_W  (DS_W),
        .U_BIT (U_BIT),
        .M_BIT (M_BIT)
    ) u_ctx (
        .cur       (ctx_q),
        .pc        (pc_q),
        .ksp       (ksp_q),
        .dslot     (dslot_q),
        .is_nmi    (is_nmi),
        .vec       (vec),
        .legacy    (legacy_q),
        .nxt       (ctx_nxt),
        .dslot_nxt (dslot_nxt)
    );

    assign mem_addr_o = vec_addr(ebp_q, vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q    <= EXC_IRQ;
            legacy_q <= 1'b0;
            pc_q     <= '0;
            ebp_q    <= '0;
            ksp_q    <= '0;
            dslot_q  <= '0;
            trap_q   <= '0;
            fault_q  <= '0;
            irq_q    <= '0;
            ctx_q    <= '0;
        end else if (accept) begin
            cls_q     <= exc_cls_e'(cls_i);
            legacy_q  <= legacy_in;
            pc_q      <= pc_i;
            ebp_q     <= ebp_i;
            ksp_q     <= ksp_i;
            dslot_q   <= dslot_i;
            trap_q    <= trap_vec_i;
            fault_q   <= fault_vec_i;
            irq_q     <= irq_vec_i;
            ctx_q.erp <= erp_i;
            ctx_q.nrp <= nrp_i;
            ctx_q.ccs <= ccs_i;
            ctx_q.exs <= exs_i;
            ctx_q.sp  <= sp_i;
            ctx_q.usp <= usp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_o_q  <= '0;
            pc_o     <= '0;
            dslot_o  <= '0;
            locked_o <= 1'b0;
        end else if (commit) begin
            ctx_o_q <= ctx_nxt;
            pc_o    <= mem_rsp_data_i;
            dslot_o <= dslot_nxt;
            if (legacy_q) locked_o <= 1'b1;
        end
    end

    always_comb begin
        erp_o = ctx_o_q.erp;
        nrp_o = ctx_o_q.nrp;
        ccs_o = ctx_o_q.ccs;
        exs_o = ctx_o_q.exs;
        sp_o  = ctx_o_q.sp;
        usp_o = ctx_o_q.usp;
    end

    // R10: no partial state visible outside the done cycle
    a_r10_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(pc_o) && $stable(ccs_o) && $stable(erp_o)
                     && $stable(sp_o) && $stable(exs_o) && $stable(locked_o)));

    // R2: address does not move while the request waits
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=> $stable(mem_addr_o));

    // R7: full-path entry always leaves kernel mode in the status word
    a_r7_user_cleared: assert property (@(posedge clk) disable iff (rst)
        (done_o && !legacy_q) |-> !ccs_o[U_BIT]);

    // R9: an error never coincides with a fetch or busy phase
    a_r9_err_no_req: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!mem_req_valid_o && !busy_o && !done_o));

endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

    localparam int CLK_PERIOD = 10;
    localparam int U_B = 8;
    localparam int M_B = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  cls_i = '0;
    logic [7:0]  ver_i = '0;
    logic [31:0] pc_i = '0, ccs_i = '0, ebp_i = '0, sp_i = '0, ksp_i = '0;
    logic [31:0] usp_i = '0, erp_i = '0, nrp_i = '0, exs_i = '0;
    logic [1:0]  dslot_i = '0;
    logic [7:0]  trap_vec_i = '0, fault_vec_i = '0, irq_vec_i = '0;
    logic        busy_o, done_o, err_o, mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic [31:0] pc_o, erp_o, nrp_o, ccs_o, exs_o, sp_o, usp_o;
    logic [1:0]  dslot_o;
    logic        locked_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .cls_i(cls_i), .ver_i(ver_i),
        .pc_i(pc_i), .dslot_i(dslot_i), .ccs_i(ccs_i), .ebp_i(ebp_i),
        .sp_i(sp_i), .ksp_i(ksp_i), .usp_i(usp_i), .erp_i(erp_i),
        .nrp_i(nrp_i), .exs_i(exs_i), .trap_vec_i(trap_vec_i),
        .fault_vec_i(fault_vec_i), .irq_vec_i(irq_vec_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .pc_o(pc_o), .erp_o(erp_o),
        .nrp_o(nrp_o), .ccs_o(ccs_o), .exs_o(exs_o), .sp_o(sp_o),
        .usp_o(usp_o), .dslot_o(dslot_o), .locked_o(locked_o)
    );

    // memory model: one request at a time, latency 'lat' on both phases
    int          lat = 0;
    int          wcnt = 0;
    logic        pend = 1'b0;
    logic        last_pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          req_total = 0;
    logic [31:0] last_addr = '0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    always @(posedge clk) begin
        if (mem_req_valid_o && mem_req_ready_i) begin
            pend      <= 1'b1;
            pend_addr <= mem_addr_o;
            last_addr <= mem_addr_o;
            req_total <= req_total + 1;
        end else if (mem_rsp_valid_i) begin
            pend <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (pend != last_pend) wcnt = 0;
        last_pend = pend;
        mem_req_ready_i = 1'b0;
        mem_rsp_valid_i = 1'b0;
        if (!rst) begin
            if (!pend) begin
                if (mem_req_valid_o) begin
                    if (wcnt >= lat) mem_req_ready_i = 1'b1;
                    else wcnt++;
                end
            end else begin
                if (wcnt >= lat) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = mem_word(pend_addr);
                end else wcnt++;
            end
        end
    end

    task automatic check(input string what, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic exp_locked = 1'b0;

    task automatic run_case(input int cls, input logic [7:0] ver, input int u,
                            input int ds, input int idx, input logic [31:0] ebp,
                            input bit poke);
        logic [31:0] c_pc, c_ccs, c_sp, c_ksp, c_usp, c_erp, c_nrp, c_exs;
        logic [7:0]  tv, fv, iv, vec;
        logic [31:0] e_pc, e_erp, e_nrp, e_ccs, e_exs, e_sp, e_usp, e_addr, cw, rew;
        logic [31:0] o_pc, o_ccs, o_erp, o_sp;
        logic        leg;
        int          req0, n;
        bit          saw_busy_before;

        c_pc  = 32'h0010_0000 + idx * 32'h34;
        c_ccs = 32'hC5A3_7E9D ^ (idx * 32'h0101_0101);
        c_ccs[U_B] = u[0];
        c_ccs[M_B] = idx[0];
        c_sp  = 32'h7000_0000 + idx * 16;
        c_ksp = 32'h6000_0F00 + idx;
        c_usp = 32'h5500_0000 ^ idx;
        c_erp = 32'h0ABC_0000 + idx * 8;
        c_nrp = 32'h0DEF_0000 + idx;
        c_exs = 32'hFFFF_00FF ^ idx;
        tv = 8'h30 + 8'(idx);
        fv = 8'hE0 | 8'(idx & 15);
        iv = 8'h80 + 8'(idx * 3);
        leg = (ver < 8'd32);

        case (cls)
            0: vec = iv;
            1: vec = tv;
            2: vec = 8'h00;
            default: vec = fv;
        endcase
        e_addr = ebp + {22'b0, vec, 2'b00};
        e_pc   = mem_word(e_addr);
        rew    = leg ? 32'd0 : 32'(ds);
        cw     = c_ccs;
        e_nrp  = c_nrp;
        if (cls == 2) begin
            e_nrp = c_pc;
            e_erp = c_erp - rew;
            cw[M_B] = 1'b0;
        end else begin
            e_erp = c_pc - rew;
        end
        e_ccs = leg ? cw : {cw[31:30], cw[19:0], 10'b0};
        e_exs = leg ? c_exs : {16'b0, vec, 8'b0};
        e_sp  = u[0] ? c_ksp : c_sp;
        e_usp = u[0] ? c_sp  : c_usp;

        o_pc = pc_o; o_ccs = ccs_o; o_erp = erp_o; o_sp = sp_o;
        req0 = req_total;

        @(negedge clk);
        lat = idx % 3;
        cls_i = 2'(cls); ver_i = ver; pc_i = c_pc; dslot_i = 2'(ds);
        ccs_i = c_ccs; ebp_i = ebp; sp_i = c_sp; ksp_i = c_ksp; usp_i = c_usp;
        erp_i = c_erp; nrp_i = c_nrp; exs_i = c_exs;
        trap_vec_i = tv; fault_vec_i = fv; irq_vec_i = iv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;

        if (leg && cls == 3) begin
            // R9: illegal legacy bus fault
            check("err pulse", "R9", 32'(err_o), 32'd1);
            check("busy on error", "R9", 32'(busy_o), 32'd0);
            @(negedge clk);
            check("err one cycle", "R9", 32'(err_o), 32'd0);
            check("no fetch", "R9", 32'(req_total - req0), 32'd0);
            check("pc kept", "R9", pc_o, o_pc);
            check("ccs kept", "R9", ccs_o, o_ccs);
            check("erp kept", "R9", erp_o, o_erp);
            check("sp kept", "R9", sp_o, o_sp);
            return;
        end

        check("busy after start", "R10", 32'(busy_o), 32'd1);
        if (poke) begin
            // R10: a second start while busy must not disturb the entry
            cls_i = 2'(cls + 1); pc_i = 32'hDEAD_BEEF; ccs_i = ~c_ccs;
            ebp_i = 32'h1234_5678; trap_vec_i = ~tv; irq_vec_i = ~iv;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end

        n = 0;
        saw_busy_before = 1'b1;
        while (!done_o && n < 50) begin
            if (pc_o !== o_pc || ccs_o !== o_ccs) saw_busy_before = 1'b0;
            @(negedge clk);
            n++;
        end
        check("done reached", "R10", 32'(done_o), 32'd1);
        check("outputs held while waiting", "R10", 32'(saw_busy_before), 32'd1);
        check("idle at done", "R10", 32'(busy_o), 32'd0);
        check("one request", "R2", 32'(req_total - req0), 32'd1);
        check("fetch address (vector)", "R1", last_addr, e_addr);
        check("new pc", "R2", pc_o, e_pc);
        check("erp", "R3", erp_o, e_erp);
        check("nrp", "R3", nrp_o, e_nrp);
        check("exs", "R4", exs_o, e_exs);
        check("dslot", "R5", 32'(dslot_o), leg ? 32'(ds) : 32'd0);
        check("sp", "R6", sp_o, e_sp);
        check("usp", "R6", usp_o, e_usp);
        check("ccs", "R7", ccs_o, e_ccs);
        if (leg) exp_locked = 1'b1;
        check("locked", "R8", 32'(locked_o), 32'(exp_locked));
        @(negedge clk);
        check("done pulse width", "R10", 32'(done_o), 32'd0);
        check("pc after done", "R10", pc_o, e_pc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] vers [4];
        int idx;
        vers[0] = 8'd5; vers[1] = 8'd31; vers[2] = 8'd32; vers[3] = 8'd200;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check("pc reset", "R11", pc_o, 32'd0);
        check("ccs reset", "R11", ccs_o, 32'd0);
        check("erp reset", "R11", erp_o, 32'd0);
        check("sp reset", "R11", sp_o, 32'd0);
        check("exs reset", "R11", exs_o, 32'd0);
        check("flags reset", "R11",
              {27'b0, busy_o, done_o, err_o, mem_req_valid_o, locked_o}, 32'd0);

        // start with new-version entries so locked_o's hold is visible first
        idx = 0;
        for (int vs = 3; vs >= 0; vs--) begin
            for (int cls = 0; cls < 4; cls++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int ds = 0; ds < 4; ds++) begin
                        run_case(cls, vers[vs], u, ds, idx,
                                 32'h8000_1000 + idx * 32'h100, 1'b0);
                        idx++;
                    end
                end
            end
        end
        // R2: table base wrapping past the top of the address space
        run_case(1, 8'd40, 1, 2, 7, 32'hFFFF_FFF0, 1'b0);
        run_case(0, 8'd3, 0, 1, 8, 32'hFFFF_FF00, 1'b0);
        // R10: start while busy is ignored
        run_case(0, 8'd50, 1, 1, 11, 32'h4000_0000, 1'b1);
        run_case(2, 8'd10, 0, 3, 14, 32'h4000_2000, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule